// File: doc/BRIEF.md
# Single/Double to 80-bit Extended Precision Widener

This block turns a floating-point memory operand, held either in the 32-bit or in the 64-bit IEEE-754 binary format, into an 80-bit extended-precision value ready for a divider or another arithmetic unit. The result has a sign bit, a 15-bit exponent biased by 16383, and a 64-bit significand whose top bit is an explicit integer bit, decoded from the input exponent field rather than implied.

A format-select input (`fmt_dbl`) says how to read the 64-bit input bus. All work is done in one combinational stage, and the result is registered once, so both widths cost the same single clock cycle. Subnormal inputs come out normalized, because the wider exponent range can always hold them. Equal values in either input format therefore give bit-identical results. A signalling NaN is made quiet and raises a one-cycle invalid flag.

Top module: `fpw_widen80`

## Requirements
- R1: The result appears on the outputs at the first rising clock edge after the input is applied, and stays there until the next edge. While `rst_n` is low, all outputs are 0.
- R2: With `fmt_dbl`=0, the input is `src[31:0]`: sign at bit 31, an 8-bit exponent at bits 30:23 and a 23-bit fraction at bits 22:0. Bits 63:32 have no effect. With `fmt_dbl`=1, the input is `src[63:0]`: sign at bit 63, an 11-bit exponent at bits 62:52 and a 52-bit fraction at bits 51:0.
- R3: A normal input (exponent field neither all-zero nor all-one) gives an output exponent equal to the field plus 16256 (single) or plus 15360 (double). Significand bit 63 is 1. The fraction sits in bits 62 downward, and every lower bit is 0.
- R4: A single and a double input that encode the same value give identical sign, exponent, significand and invalid outputs.
- R5: A zero input of either sign gives an exponent of 0 and a significand of 0, and keeps the input sign.
- R6: A subnormal input (exponent field 0, fraction nonzero) is normalized. The significand is shifted left until bit 63 is 1, and the exponent is 16256 (single) or 15360 (double) minus the number of leading zeros of the fraction.
- R7: An infinity gives exponent 0x7FFF and significand 0x8000000000000000 with the sign kept, and `invalid` stays 0.
- R8: A quiet NaN (top fraction bit 1) gives exponent 0x7FFF and significand bit 63 set, with the fraction left-aligned below it. `invalid` stays 0.
- R9: A signalling NaN (top fraction bit 0, fraction nonzero) comes out as R8 with significand bit 62 forced to 1, and `invalid` is 1 for exactly that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_dbl | input | 1 | 0: single-precision operand, 1: double-precision operand |
| src | input | 64 | Operand bus |
| ext_sign | output | 1 | Result sign |
| ext_exp | output | 15 | Result exponent, bias 16383 |
| ext_sig | output | 64 | Result significand, explicit integer bit at 63 |
| invalid | output | 1 | Signalling NaN seen in the registered result |

## Verification
Every result is due exactly one rising edge after its operand is driven, whatever the format or class of the value. The bench drives each operand on a falling edge, waits for the next rising edge and compares on the falling edge after it, so the comparison always sees the registered result of that operand alone. The one-cycle life of `invalid` is checked by sampling one cycle after a signalling NaN is followed by a quiet one. The checker's clocked properties compare the outputs with the operand taken one cycle in the past.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    // extended result layout
    localparam int EXT_EXP_W  = 15;
    localparam int EXT_SIG_W  = 64;
    localparam int EXT_FRAC_W = EXT_SIG_W - 1;
    localparam int EXT_BIAS   = (1 << (EXT_EXP_W - 1)) - 1;

    // input layouts
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W;
    localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;

    localparam int LZ_W = $clog2(EXT_FRAC_W + 1);

    typedef struct packed {
        logic                 sign;
        logic [EXT_EXP_W-1:0] exp;
        logic [EXT_SIG_W-1:0] sig;
        logic                 inv;
    } ext_t;
endpackage

// File: rtl/fpw_unpack.sv
module fpw_unpack
    import fpw_pkg::*;
(
    input  logic                  fmt_dbl,
    input  logic [DBL_W-1:0]      src,
    output logic                  sign,
    output logic [DBL_EXP_W-1:0]  exp_field,
    output logic                  exp_zero,
    output logic                  exp_ones,
    output logic [EXT_FRAC_W-1:0] frac,
    output logic [EXT_EXP_W-1:0]  bias_adj
);
    localparam int SGL_PAD = EXT_FRAC_W - SGL_FRAC_W;
    localparam int DBL_PAD = EXT_FRAC_W - DBL_FRAC_W;
    localparam logic [EXT_EXP_W-1:0] SGL_ADJ = EXT_EXP_W'(EXT_BIAS - SGL_BIAS);
    localparam logic [EXT_EXP_W-1:0] DBL_ADJ = EXT_EXP_W'(EXT_BIAS - DBL_BIAS);

    always_comb begin
        if (fmt_dbl) begin
            sign      = src[DBL_W-1];
            exp_field = src[DBL_W-2 -: DBL_EXP_W];
            exp_zero  = (src[DBL_W-2 -: DBL_EXP_W] == '0);
            exp_ones  = &src[DBL_W-2 -: DBL_EXP_W];
            frac      = {src[DBL_FRAC_W-1:0], {DBL_PAD{1'b0}}};
            bias_adj  = DBL_ADJ;
        end else begin
            sign      = src[SGL_W-1];
            exp_field = DBL_EXP_W'(src[SGL_W-2 -: SGL_EXP_W]);
            exp_zero  = (src[SGL_W-2 -: SGL_EXP_W] == '0);
            exp_ones  = &src[SGL_W-2 -: SGL_EXP_W];
            frac      = {src[SGL_FRAC_W-1:0], {SGL_PAD{1'b0}}};
            bias_adj  = SGL_ADJ;
        end
    end
endmodule

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
    parameter int W   = 63,
    parameter int CNT = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec,
    output logic [CNT-1:0] count
);
    // per-bit "first one" indication, then encode
    logic [W-1:0] seen;

    genvar g;
    generate
        for (g = W - 1; g >= 0; g--) begin : g_scan
            if (g == W - 1) begin : g_top
                assign seen[g] = vec[g];
            end else begin : g_rest
                assign seen[g] = vec[g] | seen[g+1];
            end
        end
    endgenerate

    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            if (!seen[i]) count = count + CNT'(1);
        end
    end
endmodule

// File: rtl/fpw_widen80.sv
module fpw_widen80
    import fpw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fmt_dbl,
    input  logic [DBL_W-1:0]     src,
    output logic                 ext_sign,
    output logic [EXT_EXP_W-1:0] ext_exp,
    output logic [EXT_SIG_W-1:0] ext_sig,
    output logic                 invalid
);
    logic                  u_sign;
    logic [DBL_EXP_W-1:0]  u_exp;
    logic                  u_ezero;
    logic                  u_eones;
    logic [EXT_FRAC_W-1:0] u_frac;
    logic [EXT_EXP_W-1:0]  u_adj;
    logic [LZ_W-1:0]       lz;
    logic [LZ_W:0]         shamt;

    ext_t res_d, res_q;

    fpw_unpack u_unpack (
        .fmt_dbl  (fmt_dbl),
        .src      (src),
        .sign     (u_sign),
        .exp_field(u_exp),
        .exp_zero (u_ezero),
        .exp_ones (u_eones),
        .frac     (u_frac),
        .bias_adj (u_adj)
    );

    fpw_lzc #(.W(EXT_FRAC_W), .CNT(LZ_W)) u_lzc (
        .vec  (u_frac),
        .count(lz)
    );

    assign shamt = {1'b0, lz} + (LZ_W+1)'(1);

    always_comb begin
        res_d      = '0;
        res_d.sign = u_sign;
        if (u_eones) begin
            res_d.exp = '1;
            res_d.sig = {1'b1, u_frac};
            if ((u_frac != '0) && !u_frac[EXT_FRAC_W-1]) begin
                res_d.sig[EXT_SIG_W-2] = 1'b1;
                res_d.inv              = 1'b1;
            end
        end else if (u_ezero) begin
            if (u_frac != '0) begin
                res_d.exp = u_adj - EXT_EXP_W'(lz);
                res_d.sig = {1'b0, u_frac} << shamt;
            end
        end else begin
            res_d.exp = u_adj + EXT_EXP_W'(u_exp);
            res_d.sig = {1'b1, u_frac};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign ext_sign = res_q.sign;
    assign ext_exp  = res_q.exp;
    assign ext_sig  = res_q.sig;
    assign invalid  = res_q.inv;
endmodule

// File: rtl/fpw_widen80_chk.sv
module fpw_widen80_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fmt_dbl,
    input logic [63:0] src,
    input logic        ext_sign,
    input logic [14:0] ext_exp,
    input logic [63:0] ext_sig,
    input logic        invalid
);
    logic        c_sign, c_ez, c_eo, c_fz, c_ftop;
    logic [14:0] c_norm_exp;

    always_comb begin
        if (fmt_dbl) begin
            c_sign     = src[63];
            c_ez       = (src[62:52] == 11'd0);
            c_eo       = (src[62:52] == 11'h7FF);
            c_fz       = (src[51:0] == 52'd0);
            c_ftop     = src[51];
            c_norm_exp = {4'd0, src[62:52]} + 15'd15360;
        end else begin
            c_sign     = src[31];
            c_ez       = (src[30:23] == 8'd0);
            c_eo       = (src[30:23] == 8'hFF);
            c_fz       = (src[22:0] == 23'd0);
            c_ftop     = src[22];
            c_norm_exp = {7'd0, src[30:23]} + 15'd16256;
        end
    end

    // R3: normal operand gives re-biased exponent and integer bit one
    a_r3_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!c_ez && !c_eo)) |->
            (ext_exp == $past(c_norm_exp)) && ext_sig[63] && (ext_sign == $past(c_sign)));

    // R5: zero keeps sign and clears exponent and significand
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(c_ez && c_fz)) |->
            (ext_exp == 15'd0) && (ext_sig == 64'd0) && (ext_sign == $past(c_sign)));

    // R6: a subnormal comes out normalized
    a_r6_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(c_ez && !c_fz)) |-> ext_sig[63] && (ext_exp != 15'd0));

    // R7: infinity
    a_r7_inf: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(c_eo && c_fz)) |->
            (ext_exp == 15'h7FFF) && (ext_sig == 64'h8000_0000_0000_0000) && !invalid);

    // R9: invalid only follows a signalling NaN, and the result is quiet
    a_r9_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && invalid) |->
            $past(c_eo && !c_fz && !c_ftop) && (ext_exp == 15'h7FFF) && (ext_sig[63:62] == 2'b11));

    // R8: quiet NaN passes without invalid
    a_r8_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(c_eo && c_ftop)) |-> !invalid && (ext_sig[63:62] == 2'b11));
endmodule

bind fpw_widen80 fpw_widen80_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fmt_dbl (fmt_dbl),
    .src     (src),
    .ext_sign(ext_sign),
    .ext_exp (ext_exp),
    .ext_sig (ext_sig),
    .invalid (invalid)
);

// File: tb/fpw_widen80_test.sv
`timescale 1ns/1ps
module fpw_widen80_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic [63:0] src = 64'd0;
    logic        ext_sign;
    logic [14:0] ext_exp;
    logic [63:0] ext_sig;
    logic        invalid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fpw_widen80 uut (
        .clk(clk), .rst_n(rst_n), .fmt_dbl(fmt_dbl), .src(src),
        .ext_sign(ext_sign), .ext_exp(ext_exp), .ext_sig(ext_sig), .invalid(invalid)
    );

    // {fmt, src, sign, exp, sig, inv}
    localparam int NV = 20;
    localparam logic [145:0] VEC [NV] = '{
        {1'b0, 64'h0000_0000_3F80_0000, 1'b0, 15'h3FFF, 64'h8000_0000_0000_0000, 1'b0}, // R3 1.0
        {1'b1, 64'h3FF0_0000_0000_0000, 1'b0, 15'h3FFF, 64'h8000_0000_0000_0000, 1'b0}, // R3 R4 1.0
        {1'b0, 64'h0000_0000_C020_0000, 1'b1, 15'h4000, 64'hA000_0000_0000_0000, 1'b0}, // R3 -2.5
        {1'b1, 64'hC004_0000_0000_0000, 1'b1, 15'h4000, 64'hA000_0000_0000_0000, 1'b0}, // R4 -2.5
        {1'b0, 64'h0000_0000_7F7F_FFFF, 1'b0, 15'h407E, 64'hFFFF_FF00_0000_0000, 1'b0}, // R3 max single
        {1'b1, 64'h3FF0_0000_0000_0001, 1'b0, 15'h3FFF, 64'h8000_0000_0000_0800, 1'b0}, // R3 low bit
        {1'b1, 64'h0010_0000_0000_0000, 1'b0, 15'h3C01, 64'h8000_0000_0000_0000, 1'b0}, // R3 min normal
        {1'b0, 64'hDEAD_BEEF_3F80_0000, 1'b0, 15'h3FFF, 64'h8000_0000_0000_0000, 1'b0}, // R2 upper ignored
        {1'b0, 64'h0000_0000_0000_0000, 1'b0, 15'h0000, 64'h0000_0000_0000_0000, 1'b0}, // R5 +0
        {1'b0, 64'h0000_0000_8000_0000, 1'b1, 15'h0000, 64'h0000_0000_0000_0000, 1'b0}, // R5 -0
        {1'b1, 64'h8000_0000_0000_0000, 1'b1, 15'h0000, 64'h0000_0000_0000_0000, 1'b0}, // R5 -0 dbl
        {1'b0, 64'h0000_0000_0000_0001, 1'b0, 15'h3F6A, 64'h8000_0000_0000_0000, 1'b0}, // R6 min sub
        {1'b1, 64'h0000_0000_0000_0001, 1'b0, 15'h3BCD, 64'h8000_0000_0000_0000, 1'b0}, // R6 min sub dbl
        {1'b0, 64'h0000_0000_007F_FFFF, 1'b0, 15'h3F80, 64'hFFFF_FE00_0000_0000, 1'b0}, // R6 max sub
        {1'b1, 64'h0008_0000_0000_0000, 1'b0, 15'h3C00, 64'h8000_0000_0000_0000, 1'b0}, // R6 top frac
        {1'b0, 64'h0000_0000_7F80_0000, 1'b0, 15'h7FFF, 64'h8000_0000_0000_0000, 1'b0}, // R7 +inf
        {1'b1, 64'hFFF0_0000_0000_0000, 1'b1, 15'h7FFF, 64'h8000_0000_0000_0000, 1'b0}, // R7 -inf
        {1'b0, 64'h0000_0000_7FC0_0000, 1'b0, 15'h7FFF, 64'hC000_0000_0000_0000, 1'b0}, // R8 qnan
        {1'b0, 64'h0000_0000_7F80_0001, 1'b0, 15'h7FFF, 64'hC000_0100_0000_0000, 1'b1}, // R9 snan
        {1'b1, 64'h7FF0_0000_0000_0001, 1'b0, 15'h7FFF, 64'hC000_0000_0000_0800, 1'b1}  // R9 snan dbl
    };

    task automatic check(input string tag, input logic s, input logic [14:0] e,
                         input logic [63:0] m, input logic v);
        checks++;
        if (ext_sign !== s || ext_exp !== e || ext_sig !== m || invalid !== v) begin
            errors++;
            $display("FAIL %s: got %b/%h/%h/%b expected %b/%h/%h/%b",
                     tag, ext_sign, ext_exp, ext_sig, invalid, s, e, m, v);
        end
    endtask

    // drive on a falling edge, result registered at the next rising edge
    task automatic apply(input logic f, input logic [63:0] d);
        @(negedge clk);
        fmt_dbl = f;
        src     = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [145:0] v;
        logic [63:0]  sig_a;
        logic [14:0]  exp_a;
        // R1: reset state with a live operand on the bus
        fmt_dbl = 1'b1;
        src     = 64'hFFF0_0000_0000_0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 1'b0, 15'd0, 64'd0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            apply(v[145], v[144:81]);
            check($sformatf("vector %0d (R2-R9)", i), v[80], v[79:65], v[64:1], v[0]);
        end

        // R4: same value as double and single, compared directly
        apply(1'b1, 64'hBFC0_0000_0000_0000);   // -0.125
        sig_a = ext_sig;
        exp_a = ext_exp;
        apply(1'b0, 64'h0000_0000_BE00_0000);   // -0.125
        check("R4 pair", 1'b1, exp_a, sig_a, 1'b0);

        // R9: invalid lasts one result only
        apply(1'b0, 64'h0000_0000_7FA0_0000);
        check("R9 snan", 1'b0, 15'h7FFF, 64'hE000_0000_0000_0000, 1'b1);
        apply(1'b0, 64'h0000_0000_7FE0_0000);
        check("R9 flag drops", 1'b0, 15'h7FFF, 64'hE000_0000_0000_0000, 1'b0);

        // R1: value held while the bus stays put, then reset clears
        @(posedge clk);
        @(negedge clk);
        check("R1 hold", 1'b0, 15'h7FFF, 64'hE000_0000_0000_0000, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 1'b0, 15'd0, 64'd0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule